// File: doc/BRIEF.md
# Page Access Permission and Protection-ID Checker

This combinational block decides whether a single memory access to an already translated page may proceed. It takes the lookup result for the page, the kind of access being attempted, the current privilege level and the rights fields held in the page's translation entry. It returns the set of rights the access would hold on that page and a fault code. The fault code follows a fixed priority: a lookup miss first, then a protection-ID fault, then an access-rights fault.

Rights come from two sources, and an access needs both. The first is the entry's rights-type code together with two privilege bounds. Read and write each have an upper bound on privilege. Execute is allowed only when the privilege lies inside a window between the two bounds. The second is a protection-ID match. The entry's access ID is searched for among the slots of four protection-ID registers. The first matching slot grants all rights, or all except write when its lowest bit is set. A public page (access ID zero) skips this search, and so does any access made while protection checking is off. With the `WIDE` parameter set, each register holds two 32-bit slots, and the low slot is searched before the high one.

Top module: `prot_gate`

## Requirements
- R1: With privilege p and entry bounds b1 (`pl_hi`) and b2 (`pl_lo`), the read right needs p <= b1, the write right needs p <= b2, and the execute right needs b2 <= p <= b1. A smaller number means more privilege.
- R2: The rights-type codes map to rights as follows. Code 0 gives read only. Code 1 gives read and write. Code 2 gives read and execute. Code 3 gives all three. Codes 4 to 7 give execute only. Each right is still subject to R1.
- R3: The protection-ID search is skipped when the whole access ID is zero or `pchk_en` is low. In that case the ID mask is all rights and no protection-ID fault can occur.
- R4: A slot matches when its bits [16:1] equal bits [15:0] of the access ID. A matching slot with bit 0 set grants read and execute. A matching slot with bit 0 clear grants read, write and execute. When no slot matches, the ID mask is empty.
- R5: Slot k occupies bits [32k+31:32k] of `pid_regs`. The slots are searched from the lowest k upward, and the first match wins. With `WIDE`=1 there are eight slots, so each register's low half comes before its high half. With `WIDE`=0 there are four.
- R6: When `hit` is low, `perm` is 0. The fault is 1 for an execute access and 2 for any other access, whatever the other inputs are.
- R7: On a hit where the search was not skipped and the ID mask lacks the requested right, the fault is 3 for an execute access and 4 for any other access.
- R8: On a hit, `perm` is the rights mask ANDed with the ID mask. If R7 does not apply and `perm` lacks the requested right, the fault is 3 for execute and 5 for any other access. Otherwise the fault is 0.
- R9: `acc` encodes the access kind as 0 read, 1 write, 2 execute, and 3 is treated as read. The `perm` bits are bit 0 read, bit 1 write and bit 2 execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hit | input | 1 | Translation lookup found an entry |
| acc | input | 2 | Access kind (R9) |
| priv | input | 2 | Current privilege level, 0 most privileged |
| pchk_en | input | 1 | Protection-ID checking enabled |
| art | input | 3 | Entry rights-type code |
| pl_hi | input | 2 | Entry bound for read and upper end of the execute window |
| pl_lo | input | 2 | Entry bound for write and lower end of the execute window |
| aid | input | AID_W (31) | Entry access ID |
| pid_regs | input | 4*(WIDE?64:32) (256) | Four protection-ID registers, register 0 lowest |
| perm | output | 3 | Rights held on the page {x,w,r} |
| fault | output | 3 | 0 none, 1 instruction miss, 2 data miss, 3 instruction protection, 4 data protection-ID, 5 data access rights |

## Verification
The bench builds two copies side by side. One has `WIDE`=1 with eight 32-bit ID slots, and the other has `WIDE`=0 with four. Both use a 31-bit access ID compared over 16 bits. For each of seven protection-ID configurations, the bench sweeps every combination of hit, access kind, privilege, rights type and both bounds. This brings every execute-window edge and every fault priority within reach. The configurations cover both ways of skipping the search, a search with no match, first-match order across halves and across registers, and garbage in the bits outside the comparison. In one configuration only the high halves match, so the narrow copy must report no match where the wide copy finds one.

// File: rtl/prot_gate.sv
module prot_gate #(
  parameter bit WIDE  = 1'b1,
  parameter int AID_W = 31,
  parameter int CMP_W = 16,
  localparam int PID_W = WIDE ? 64 : 32,
  localparam int NSLOT = WIDE ? 8 : 4
) (
  input  logic               hit,
  input  logic [1:0]         acc,
  input  logic [1:0]         priv,
  input  logic               pchk_en,
  input  logic [2:0]         art,
  input  logic [1:0]         pl_hi,
  input  logic [1:0]         pl_lo,
  input  logic [AID_W-1:0]   aid,
  input  logic [4*PID_W-1:0] pid_regs,
  output logic [2:0]         perm,
  output logic [2:0]         fault
);

  localparam logic [2:0] M_R = 3'b001;
  localparam logic [2:0] M_W = 3'b010;
  localparam logic [2:0] M_X = 3'b100;

  logic [2:0] req;
  logic       is_x;
  assign is_x = (acc == 2'd2);
  assign req  = (acc == 2'd1) ? M_W : is_x ? M_X : M_R;

  logic r_ok, w_ok, x_ok;
  assign r_ok = priv <= pl_hi;
  assign w_ok = priv <= pl_lo;
  assign x_ok = (pl_lo <= priv) && (priv <= pl_hi);

  logic [2:0] ar_mask;
  always_comb begin
    case (art)
      3'd0:    ar_mask = {1'b0, 1'b0, r_ok};
      3'd1:    ar_mask = {1'b0, w_ok, r_ok};
      3'd2:    ar_mask = {x_ok, 1'b0, r_ok};
      3'd3:    ar_mask = {x_ok, w_ok, r_ok};
      default: ar_mask = {x_ok, 1'b0, 1'b0};
    endcase
  end

  logic [NSLOT-1:0] slot_hit;
  logic [2:0]       slot_grant [NSLOT];
  logic [NSLOT-1:0] unused_slot_bits;

  genvar k;
  generate
    for (k = 0; k < NSLOT; k++) begin : g_slot
      logic [31:0] s;
      assign s = pid_regs[32*k +: 32];
      assign slot_hit[k]   = (s[CMP_W:1] == aid[CMP_W-1:0]);
      assign slot_grant[k] = s[0] ? (M_R | M_X) : (M_R | M_W | M_X);
      assign unused_slot_bits[k] = ^s[31:CMP_W+1];
    end
  endgenerate

  logic [2:0] match_mask;
  always_comb begin
    match_mask = 3'b000;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (slot_hit[i]) match_mask = slot_grant[i];
  end

  logic       skip;
  logic [2:0] id_mask, eff;
  assign skip    = (aid == '0) || !pchk_en;
  assign id_mask = skip ? 3'b111 : match_mask;
  assign eff     = ar_mask & id_mask;

  always_comb begin
    if (!hit)                      fault = is_x ? 3'd1 : 3'd2;
    else if ((id_mask & req) == 0) fault = is_x ? 3'd3 : 3'd4;
    else if ((eff & req) == 0)     fault = is_x ? 3'd3 : 3'd5;
    else                           fault = 3'd0;
  end

  assign perm = hit ? eff : 3'b000;

  always_comb begin
    p_miss_first_r6: assert (hit || (perm == 3'b000 && (fault == 3'd1 || fault == 3'd2)))
      else $error("miss must dominate");
    p_read_bound_r1: assert (!perm[0] || priv <= pl_hi)
      else $error("read beyond bound");
    p_write_bound_r1: assert (!perm[1] || priv <= pl_lo)
      else $error("write beyond bound");
    p_exec_window_r1: assert (!perm[2] || (pl_lo <= priv && priv <= pl_hi))
      else $error("execute outside window");
    p_ro_page_r2: assert (!(hit && art == 3'd0) || perm[2:1] == 2'b00)
      else $error("read-only page grants more");
    p_skip_no_idfault_r3: assert (!(hit && (aid == '0 || !pchk_en)) || fault != 3'd4)
      else $error("skipped check raised id fault");
    p_grant_means_ok_r8: assert (!(hit && fault == 3'd0) || (perm & req) != 3'b000)
      else $error("no fault without right");
  end

endmodule

// File: tb/prot_gate_bench.sv
module prot_gate_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         hit, pchk_en;
  logic [1:0]   acc, priv, pl_hi, pl_lo;
  logic [2:0]   art;
  logic [30:0]  aid;
  logic [255:0] pid_w;
  logic [127:0] pid_n;
  logic [2:0]   perm_w, fault_w, perm_n, fault_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  prot_gate #(.WIDE(1'b1), .AID_W(31), .CMP_W(16)) u_prot_gate (
    .hit(hit), .acc(acc), .priv(priv), .pchk_en(pchk_en), .art(art),
    .pl_hi(pl_hi), .pl_lo(pl_lo), .aid(aid), .pid_regs(pid_w),
    .perm(perm_w), .fault(fault_w));

  prot_gate #(.WIDE(1'b0), .AID_W(31), .CMP_W(16)) u_prot_gate_narrow (
    .hit(hit), .acc(acc), .priv(priv), .pchk_en(pchk_en), .art(art),
    .pl_hi(pl_hi), .pl_lo(pl_lo), .aid(aid), .pid_regs(pid_n),
    .perm(perm_n), .fault(fault_n));

  localparam logic [31:0] RO  = 32'h0000_2469;
  localparam logic [31:0] RW  = 32'h0000_2468;
  localparam logic [31:0] NOM = 32'h0000_1111;

  function automatic logic [2:0] ar_of(int t, int p, int b1, int b2);
    logic r, w, x;
    r = p <= b1; w = p <= b2; x = (b2 <= p) && (p <= b1);
    case (t)
      0: return {1'b0, 1'b0, r};
      1: return {1'b0, w, r};
      2: return {x, 1'b0, r};
      3: return {x, w, r};
      default: return {x, 1'b0, 1'b0};
    endcase
  endfunction

  task automatic check_one(string tag, string which, logic [2:0] gp, logic [2:0] gf,
                           logic [2:0] ep, logic [2:0] ef);
    string rt;
    checks++;
    if (ef == 1 || ef == 2) rt = "R6";
    else if (ef == 4) rt = "R7";
    else rt = "R8 R1 R2 R9";
    if (gp !== ep || gf !== ef) begin
      errors++;
      $display("FAIL %s %s %s: hit=%0d acc=%0d priv=%0d art=%0d hi=%0d lo=%0d perm=%b exp=%b fault=%0d exp=%0d",
               rt, tag, which, hit, acc, priv, art, pl_hi, pl_lo, gp, ep, gf, ef);
    end
  endtask

  function automatic void expect_of(logic [2:0] idm, bit skp, logic [2:0] ar, int a, bit h,
                                    output logic [2:0] ep, output logic [2:0] ef);
    logic [2:0] rq;
    bit ex;
    ex = (a == 2);
    rq = (a == 1) ? 3'b010 : ex ? 3'b100 : 3'b001;
    ep = h ? (ar & idm) : 3'b000;
    if (!h) ef = ex ? 3'd1 : 3'd2;
    else if (!skp && (idm & rq) == 0) ef = ex ? 3'd3 : 3'd4;
    else if ((ar & idm & rq) == 0) ef = ex ? 3'd3 : 3'd5;
    else ef = 3'd0;
  endfunction

  task automatic sweep(string tag, logic [30:0] a_id, bit en, logic [255:0] pw, logic [127:0] pn,
                       bit skp, logic [2:0] mw, logic [2:0] mn);
    aid = a_id; pchk_en = en; pid_w = pw; pid_n = pn;
    for (int h = 0; h < 2; h++)
      for (int a = 0; a < 4; a++)
        for (int p = 0; p < 4; p++)
          for (int t = 0; t < 8; t++)
            for (int b1 = 0; b1 < 4; b1++)
              for (int b2 = 0; b2 < 4; b2++) begin
                logic [2:0] ar, ep, ef;
                hit = h[0]; acc = a[1:0]; priv = p[1:0]; art = t[2:0];
                pl_hi = b1[1:0]; pl_lo = b2[1:0];
                #1;
                ar = ar_of(t, p, b1, b2);
                expect_of(skp ? 3'b111 : mw, skp, ar, a, h[0], ep, ef);
                check_one(tag, "wide", perm_w, fault_w, ep, ef);
                expect_of(skp ? 3'b111 : mn, skp, ar, a, h[0], ep, ef);
                check_one(tag, "narrow", perm_n, fault_n, ep, ef);
              end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    hit = 0; acc = 2'd0; priv = 0; art = 0; pl_hi = 0; pl_lo = 0;
    aid = '0; pchk_en = 1; pid_w = '0; pid_n = '0;
    @(negedge clk);
    checks++;
    if (perm_w !== 3'b000 || fault_w !== 3'd2) begin
      errors++;
      $display("FAIL R6 idle: perm=%b exp=000 fault=%0d exp=2", perm_w, fault_w);
    end

    // R3: public page, slots would otherwise forbid write
    sweep("R3 public", 31'd0, 1'b1, {8{32'h0000_0001}}, {4{32'h0000_0001}}, 1'b1, 3'b000, 3'b000);
    // R3: checking disabled
    sweep("R3 disabled", 31'h1234, 1'b0, {8{RO}}, {4{RO}}, 1'b1, 3'b000, 3'b000);
    // R4: no slot matches
    sweep("R4 nomatch", 31'h1234, 1'b1, {8{NOM}}, {4{NOM}}, 1'b0, 3'b000, 3'b000);
    // R5: register 0 high half beats register 1 low half
    sweep("R5 hi-before-next", 31'h1234, 1'b1,
          {NOM, NOM, NOM, NOM, NOM, RW, RO, NOM}, {RO, RW, NOM, NOM},
          1'b0, 3'b101, 3'b111);
    // R5: low half beats high half
    sweep("R5 lo-first", 31'h1234, 1'b1,
          {NOM, NOM, NOM, NOM, NOM, NOM, RW, RO}, {NOM, NOM, RO, RW},
          1'b0, 3'b101, 3'b111);
    // R4: 16-bit compare, upper bits of id and slot ignored
    sweep("R4 cmp16", 31'h5_1234, 1'b1,
          {32'hABC0_2468, NOM, NOM, NOM, NOM, NOM, NOM, NOM},
          {32'hFFFE_2469, NOM, NOM, NOM},
          1'b0, 3'b111, 3'b101);
    // R5: narrow variant sees only four slots
    sweep("R5 narrow-slots", 31'h1234, 1'b1,
          {NOM, NOM, RW, NOM, NOM, NOM, NOM, NOM}, {4{NOM}},
          1'b0, 3'b111, 3'b000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule